// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Timer

This block drives the active-low read and write strobes of one parallel ATA device for programmed I/O data cycles, multiword DMA data cycles and task-file register accesses. Each request picks an access class (register or data) and a direction (read or write). The block then runs up to three phases: an optional setup delay with both strobes high, a strobe-active phase, and a strobe-inactive (recovery) phase. It signals completion with a one-clock pulse in the last recovery cycle.

All timing comes from one 32-bit configuration word. Data cycles and register accesses each have their own active, inactive and setup fields. The word is sampled only when a request is accepted, so software may rewrite it while a cycle runs. The setup delay covers only the first cycle of a run. A request of the same class that arrives in the first idle cycle after completion starts its strobe at once. Ultra DMA burst timing, ready-line wait states and bus mastering are not part of this block.

Top module: `ata_strobe_timer`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces dior_n and diow_n high, busy low and done low, and abandons any cycle in progress. The first request after reset pays its full setup delay.
- R2: For a data request (req_reg=0), the strobe stays low for cfg_word[8:4]+1 clocks, then both strobes stay high for cfg_word[3:0]+1 clocks before the cycle ends.
- R3: For a register request (req_reg=1), the strobe stays low for cfg_word[17:13]+1 clocks, and the recovery phase lasts cfg_word[12:9]+1 clocks.
- R4: A request that starts from idle first spends cfg_word[24:22] clocks (data) or cfg_word[27:25] clocks (register) with busy high and both strobes high. A field value of zero gives no setup delay.
- R5: A write (req_wr=1) pulls only diow_n low; a read (req_wr=0) pulls only dior_n low. The two strobes are never low together.
- R6: A request of the same class that is accepted in the first idle cycle after done skips the setup delay.
- R7: A request accepted in that same first idle cycle, but of the other class, still gets its setup delay.
- R8: While busy is high, a request is ignored. Changes on cfg_word, req_reg and req_wr have no effect on the cycle in progress.
- R9: cfg_word bits 21:18 and 31:28, which include the DMA-enable bit 29 and the FIFO-enable bit 31, have no effect on strobe timing.
- R10: busy rises on the clock after a request is accepted while idle. done is high for exactly one clock, in the last recovery clock. busy falls on the clock after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | CFG_W (32) | Timing configuration word, sampled when a request is accepted |
| req | input | 1 | Request to start a cycle, taken only while idle |
| req_reg | input | 1 | 1 = task-file register access, 0 = data transfer |
| req_wr | input | 1 | 1 = write, 0 = read |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| busy | output | 1 | High from the clock after acceptance until the clock after done |
| done | output | 1 | One-clock pulse in the last recovery clock |

## Verification
The assertions check the properties that hold on every cycle. The two strobes are never low together, and idle means both strobes high with no done pulse. Acceptance raises busy, busy can only fall right after done, and a strobe release is always followed by recovery inside the busy window. The exact lengths of the setup, strobe and recovery phases for each field value can only be shown by the directed scenarios. So can the choice between data and register fields, the skipped setup on a same-class chained request, and the immunity to requests and configuration changes while busy. The bench compares the whole waveform of each cycle, clock by clock, against values computed from the field positions.

// File: rtl/ata_strb_pkg.sv
package ata_strb_pkg;

   // field widths of the configuration word
   localparam int TACT_W = 5;
   localparam int TREC_W = 4;
   localparam int TSET_W = 3;

   // field positions (behavioural: software packs the word this way)
   localparam int D_REC_LSB = 0;
   localparam int D_ACT_LSB = 4;
   localparam int R_REC_LSB = 9;
   localparam int R_ACT_LSB = 13;
   localparam int D_SET_LSB = 22;
   localparam int R_SET_LSB = 25;

   localparam int CFG_MIN_W = R_SET_LSB + TSET_W;

   // down-counter must hold the widest field
   localparam int CNT_W = (TACT_W > TREC_W) ?
                          ((TACT_W > TSET_W) ? TACT_W : TSET_W) :
                          ((TREC_W > TSET_W) ? TREC_W : TSET_W);

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_STROBE  = 2'd2,
      PH_RECOVER = 2'd3
   } phase_t;

   typedef struct packed {
      logic [TSET_W-1:0] setup;
      logic [TACT_W-1:0] act;
      logic [TREC_W-1:0] rec;
   } timing_t;

endpackage

// File: rtl/ata_strb_decode.sv
module ata_strb_decode
   import ata_strb_pkg::*;
#(
   parameter int CFG_W = 32
) (
   input  logic [CFG_W-1:0] cfg,
   input  logic             is_reg,
   output timing_t          tim
);

   timing_t data_t;
   timing_t regs_t;

   assign data_t.setup = cfg[D_SET_LSB +: TSET_W];
   assign data_t.act   = cfg[D_ACT_LSB +: TACT_W];
   assign data_t.rec   = cfg[D_REC_LSB +: TREC_W];

   assign regs_t.setup = cfg[R_SET_LSB +: TSET_W];
   assign regs_t.act   = cfg[R_ACT_LSB +: TACT_W];
   assign regs_t.rec   = cfg[R_REC_LSB +: TREC_W];

   assign tim = is_reg ? regs_t : data_t;

   // bits outside the timing fields carry no strobe timing
   logic unused_cfg_bits;
   assign unused_cfg_bits = ^{cfg[CFG_W-1:CFG_MIN_W], cfg[D_SET_LSB-1:R_ACT_LSB+TACT_W]};

endmodule

// File: rtl/ata_strb_seq.sv
module ata_strb_seq
   import ata_strb_pkg::*;
#(
   parameter bit CHAIN_SKIP = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    is_reg,
   input  logic    is_wr,
   input  timing_t tim,
   output logic    dior_n,
   output logic    diow_n,
   output logic    busy,
   output logic    done
);

   phase_t           ph_q;
   logic [CNT_W-1:0] cnt_q;
   timing_t          tim_q;
   logic             wr_q;
   logic             last_reg_q;
   logic             follow_q;
   logic             chained;
   logic             accept;
   logic             cnt_zero;

   assign accept   = req && (ph_q == PH_IDLE);
   assign cnt_zero = (cnt_q == '0);
   assign done     = (ph_q == PH_RECOVER) && cnt_zero;
   assign busy     = (ph_q != PH_IDLE);
   assign dior_n   = !((ph_q == PH_STROBE) && !wr_q);
   assign diow_n   = !((ph_q == PH_STROBE) && wr_q);

   if (CHAIN_SKIP) begin : g_chain
      assign chained = follow_q && (is_reg == last_reg_q);
   end else begin : g_nochain
      logic unused_chain;
      assign unused_chain = ^{follow_q, last_reg_q};
      assign chained = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         cnt_q      <= '0;
         tim_q      <= '0;
         wr_q       <= 1'b0;
         last_reg_q <= 1'b0;
         follow_q   <= 1'b0;
      end else begin
         follow_q <= done;
         unique case (ph_q)
            PH_IDLE: begin
               if (accept) begin
                  tim_q      <= tim;
                  wr_q       <= is_wr;
                  last_reg_q <= is_reg;
                  if (!chained && (tim.setup != '0)) begin
                     ph_q  <= PH_SETUP;
                     cnt_q <= CNT_W'(tim.setup) - CNT_W'(1);
                  end else begin
                     ph_q  <= PH_STROBE;
                     cnt_q <= CNT_W'(tim.act);
                  end
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  ph_q  <= PH_STROBE;
                  cnt_q <= CNT_W'(tim_q.act);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_STROBE: begin
               if (cnt_zero) begin
                  ph_q  <= PH_RECOVER;
                  cnt_q <= CNT_W'(tim_q.rec);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_RECOVER: begin
               if (cnt_zero) begin
                  ph_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
   import ata_strb_pkg::*;
#(
   parameter int CFG_W      = 32,
   parameter bit CHAIN_SKIP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             req,
   input  logic             req_reg,
   input  logic             req_wr,
   output logic             dior_n,
   output logic             diow_n,
   output logic             busy,
   output logic             done
);

   if (CFG_W < CFG_MIN_W) begin : g_bad_width
      $error("ata_strobe_timer: CFG_W too narrow for timing fields");
   end

   timing_t tim;

   ata_strb_decode #(
      .CFG_W (CFG_W)
   ) i_decode (
      .cfg    (cfg_word),
      .is_reg (req_reg),
      .tim    (tim)
   );

   ata_strb_seq #(
      .CHAIN_SKIP (CHAIN_SKIP)
   ) i_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .is_reg (req_reg),
      .is_wr  (req_wr),
      .tim    (tim),
      .dior_n (dior_n),
      .diow_n (diow_n),
      .busy   (busy),
      .done   (done)
   );

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic dior_n,
   input logic diow_n,
   input logic busy,
   input logic done
);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dior_n && !diow_n));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dior_n && diow_n && !done));

   // R10
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

   // R10
   done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R8
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R2
   recover_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dior_n) |-> busy);

   // R2
   recover_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(diow_n) |-> busy);

endmodule

bind ata_strobe_timer ata_strobe_timer_chk i_chk (.*);

// File: tb/test_ata_strobe_timer.sv
module test_ata_strobe_timer;

   localparam logic [31:0] PIO0 = 32'h0d029d5e;
   localparam logic [31:0] PIO4 = 32'h0c829c62;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_word = '0;
   logic        req = 1'b0;
   logic        req_reg = 1'b0;
   logic        req_wr = 1'b0;
   logic        dior_n, diow_n, busy, done;
   int          checks = 0;
   int          fails = 0;

   always #4 clk = ~clk;

   ata_strobe_timer i_ata_strobe_timer (
      .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .req(req),
      .req_reg(req_reg), .req_wr(req_wr), .dior_n(dior_n),
      .diow_n(diow_n), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string rq, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", rq, msg);
      end
   endtask

   task automatic idle(input int k);
      repeat (k) @(negedge clk);
   endtask

   // one full cycle, compared clock by clock; leaves the bench at the
   // first idle sample so a following call is a chained request
   task automatic xfer(input logic [31:0] cw, input bit rg, input bit wr,
                       input bit chain, input bit poke, input string rq);
      int st, ac, rc, total, bad;
      string first;
      st = chain ? 0 : int'(rg ? cw[27:25] : cw[24:22]);
      ac = int'(rg ? cw[17:13] : cw[8:4]) + 1;
      rc = int'(rg ? cw[12:9] : cw[3:0]) + 1;
      total = st + ac + rc;
      cfg_word = cw; req_reg = rg; req_wr = wr; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      bad = 0;
      first = "";
      for (int n = 1; n <= total + 1; n++) begin
         logic [3:0] exp_v, got_v;
         bit strobe;
         strobe = (n > st) && (n <= st + ac);
         exp_v = {n <= total, n == total, !(strobe && !wr), !(strobe && wr)};
         got_v = {busy, done, dior_n, diow_n};
         if (got_v !== exp_v) begin
            if (bad == 0)
               first = $sformatf("clock %0d busy/done/dior_n/diow_n got %b expected %b",
                                 n, got_v, exp_v);
            bad++;
         end
         if (poke && n == 2) begin
            req = 1'b1; cfg_word = ~cw; req_reg = !rg; req_wr = !wr;
         end
         if (poke && n == 3) req = 1'b0;
         if (n <= total) @(negedge clk);
      end
      check(bad == 0, rq, first);
   endtask

   task automatic t_reset_state;
      check({dior_n, diow_n, busy, done} === 4'b1100, "R1",
            $sformatf("reset outputs got %b expected 1100", {dior_n, diow_n, busy, done}));
   endtask

   task automatic t_data_cycles;
      idle(2);
      xfer(PIO4, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R4 R10 data read PIO4");
      idle(2);
      xfer(PIO0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R5 data write PIO0");
   endtask

   task automatic t_register_cycles;
      idle(2);
      xfer(PIO0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 R4 register read PIO0");
      idle(2);
      xfer(PIO4, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R5 register write PIO4");
   endtask

   task automatic t_chaining;
      idle(2);
      xfer(PIO0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 first data cycle");
      xfer(PIO0, 1'b0, 1'b1, 1'b1, 1'b0, "R6 chained data cycle skips setup");
      xfer(PIO0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 class change keeps setup");
   endtask

   task automatic t_busy_ignore;
      idle(2);
      xfer(PIO0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 request while busy ignored");
      idle(3);
      check({busy, dior_n, diow_n} === 3'b011, "R8",
            $sformatf("after ignored request got %b expected 011", {busy, dior_n, diow_n}));
   endtask

   task automatic t_unused_bits;
      idle(2);
      xfer(PIO4 ^ 32'hF03C0000, 1'b0, 1'b0, 1'b0, 1'b0, "R9 unused bits data");
      idle(2);
      xfer(PIO0 | 32'hF03C0000, 1'b1, 1'b1, 1'b0, 1'b0, "R9 unused bits register");
   endtask

   task automatic t_extremes;
      idle(2);
      xfer(32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R2 R4 minimum fields");
      idle(2);
      xfer(32'h0FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R2 R4 maximum data fields");
      idle(2);
      xfer(32'h0FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R3 R4 maximum register fields");
   endtask

   task automatic t_mid_reset;
      idle(2);
      cfg_word = PIO0; req_reg = 1'b0; req_wr = 1'b1; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      idle(6);
      check(diow_n === 1'b0, "R1", $sformatf("strobe before reset got %b expected 0", diow_n));
      rst_n = 1'b0;
      #1;
      check({dior_n, diow_n, busy, done} === 4'b1100, "R1",
            $sformatf("mid-cycle reset got %b expected 1100", {dior_n, diow_n, busy, done}));
      @(negedge clk);
      rst_n = 1'b1;
      xfer(PIO4, 1'b0, 1'b1, 1'b0, 1'b0, "R1 first request after reset has setup");
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_data_cycles();
      t_register_cycles();
      t_chaining();
      t_busy_ignore();
      t_unused_bits();
      t_extremes();
      t_mid_reset();
      finish_run();
   end

endmodule